// File: doc/BRIEF.md
# Interpolating Trigger Timestamper

This block watches a stream of 8-bit converter samples, one per clock, and finds the moment the signal passes a programmable threshold in the chosen direction. A free-running sample counter gives the whole-sample part of the trigger time. A fraction of a sample period is then added by linear prediction: the amount by which the crossing sample overshoots the threshold is divided by the local slope. The slope is measured across four consecutive samples, two before the crossing sample and one after it. The division uses a reciprocal table indexed by the 8-bit slope magnitude, so no iterative divider is needed.

Each event keeps only a few bytes of state: two earlier samples, the overshoot, the polarity and the 32-bit count. The result comes out as a one-cycle strobe with a coarse count, an 8-bit fraction and a flag that marks whether the slope made sense. The real trigger instant is `coarse - frac/256` sample periods, which with 1 ns sampling gives steps of about 3.9 ps. A holdoff window stops ringing on the edge from triggering again.

Top module: `trig_interp_stamp`

## Requirements
- R1: While reset is held, `trig_valid_o` is 0 and `trig_coarse_o`, `trig_frac_o` and `trig_ok_o` are all 0.
- R2: With `edge_fall_i`=0, sample k triggers when sample k-1 < `level_i` and sample k >= `level_i`. Only samples with index 2 or more can trigger.
- R3: With `edge_fall_i`=1, sample k triggers when sample k-1 > `level_i` and sample k <= `level_i`. The same index rule applies.
- R4: Samples are numbered from 0, the first sample taken after reset, modulo 2^32. For a trigger on sample n, `trig_valid_o` is high for exactly one cycle: the cycle after the third rising edge, counting the edge that takes sample n. During that cycle `trig_coarse_o` = n.
- R5: The overshoot is e = x[n]-L on a rising edge and L-x[n] on a falling edge. The slope is d = x[n+1]-x[n-2]. When the slope is valid, `trig_frac_o` = min(255, (3*e*floor(65535/|d|)) >> 8), in units of 1/256 of a sample before sample n.
- R6: The slope is invalid when d = 0, when d < 0 on a rising trigger, or when d > 0 on a falling trigger. An invalid slope still produces the strobe and the coarse count, but with `trig_ok_o`=0 and `trig_frac_o`=0. A valid slope gives `trig_ok_o`=1.
- R7: After a trigger on sample n, crossings on samples n+1 to n+H-1 are ignored. H is the holdoff parameter, 5 by default, and values below 5 are raised to 5.
- R8: While `trig_valid_o` is low, `trig_coarse_o`, `trig_frac_o` and `trig_ok_o` keep the values of the last result, or the reset values if there has been no result yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 8 | Converter sample, one per clock |
| level_i | input | 8 | Trigger threshold |
| edge_fall_i | input | 1 | 0 selects a rising edge, 1 a falling edge |
| trig_valid_o | output | 1 | One-cycle result strobe |
| trig_coarse_o | output | 32 | Index of the crossing sample |
| trig_frac_o | output | 8 | Sub-sample lead before the coarse sample, in 1/256 units |
| trig_ok_o | output | 1 | Slope was usable for interpolation |

## Verification
The bound checker checks on every cycle:
- that the strobe lasts a single cycle;
- that the coarse count equals the checker's own cycle count less the three-edge latency;
- that the holdoff spacing between strobes is kept;
- that an invalid slope comes with a zero fraction;
- that the outputs hold still between strobes.

Only the bench's scenarios can show that the crossing rule and the polarity are right, and that the interpolated fraction matches the table arithmetic. These scenarios include an exact hit on the threshold, a saturating one-step jump, a reversed slope, a flat slope, fast toggling that falls inside the holdoff, and random data with changes of polarity and threshold.

// File: rtl/tis_pkg.sv
package tis_pkg;

    // polarity of the qualifying edge
    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } pol_e;

    // samples between the two ends of the slope window
    localparam int unsigned SLOPE_SPAN = 3;

    // shortest holdoff the pipeline tolerates
    localparam int unsigned HOLD_MIN = 5;

    function automatic int unsigned hold_floor(input int unsigned h);
        return (h < HOLD_MIN) ? HOLD_MIN : h;
    endfunction

endpackage

// File: rtl/tis_recip_rom.sv
module tis_recip_rom #(
    parameter int unsigned DW = 8,
    parameter int unsigned RW = 16
) (
    input  logic [DW-1:0] idx_i,
    output logic [RW-1:0] recip_o
);
    localparam int unsigned DEPTH = 1 << DW;
    localparam int unsigned FULL  = (1 << RW) - 1;

    logic [RW-1:0] table_w [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int unsigned VAL = (k == 0) ? 0 : (FULL / k);
        assign table_w[k] = RW'(VAL);
    end

    assign recip_o = table_w[idx_i];

endmodule

// File: rtl/tis_cross_detect.sv
module tis_cross_detect
    import tis_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned TW   = 32,
    parameter int unsigned HOLD = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] smp_i,
    input  logic [DW-1:0] level_i,
    input  logic          edge_fall_i,
    output logic          hit_o,
    output logic [TW-1:0] hit_ts_o,
    output logic [DW-1:0] hit_err_o,
    output logic [DW-1:0] hit_early_o,
    output logic          hit_fall_o
);
    localparam int unsigned HOLD_EFF = hold_floor(HOLD);
    localparam int unsigned HW       = $clog2(HOLD_EFF);

    typedef struct packed {
        logic [DW-1:0] prev;
        logic [DW-1:0] prev2;
        logic [1:0]    fill;
        logic [TW-1:0] cnt;
        logic [HW-1:0] hold;
        logic          hit;
        logic [TW-1:0] ts;
        logic [DW-1:0] err;
        logic [DW-1:0] early;
        logic          fall;
    } det_st_t;

    det_st_t st_d, st_q;
    pol_e    pol;
    logic    up_cross, dn_cross, any_cross, armed;

    assign pol = pol_e'(edge_fall_i);

    always_comb begin
        st_d      = st_q;
        st_d.hit  = 1'b0;
        up_cross  = (st_q.prev < level_i) && (smp_i >= level_i);
        dn_cross  = (st_q.prev > level_i) && (smp_i <= level_i);
        any_cross = (pol == POL_FALL) ? dn_cross : up_cross;
        armed     = (st_q.fill == 2'd2) && (st_q.hold == '0);

        if (armed && any_cross) begin
            st_d.hit   = 1'b1;
            st_d.ts    = st_q.cnt;
            st_d.err   = (pol == POL_FALL) ? (level_i - smp_i) : (smp_i - level_i);
            st_d.early = st_q.prev2;
            st_d.fall  = (pol == POL_FALL);
            st_d.hold  = HW'(HOLD_EFF - 1);
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end

        if (st_q.fill != 2'd2) begin
            st_d.fill = st_q.fill + 2'd1;
        end
        st_d.prev2 = st_q.prev;
        st_d.prev  = smp_i;
        st_d.cnt   = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o       = st_q.hit;
    assign hit_ts_o    = st_q.ts;
    assign hit_err_o   = st_q.err;
    assign hit_early_o = st_q.early;
    assign hit_fall_o  = st_q.fall;

endmodule

// File: rtl/tis_frac_calc.sv
module tis_frac_calc
    import tis_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned TW = 32,
    parameter int unsigned FW = 8,
    parameter int unsigned RW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] smp_i,
    input  logic          hit_i,
    input  logic [TW-1:0] hit_ts_i,
    input  logic [DW-1:0] hit_err_i,
    input  logic [DW-1:0] hit_early_i,
    input  logic          hit_fall_i,
    output logic          valid_o,
    output logic [TW-1:0] coarse_o,
    output logic [FW-1:0] frac_o,
    output logic          ok_o
);
    localparam int unsigned PW    = DW + RW + 2;
    localparam int unsigned SHIFT = RW - FW;

    typedef struct packed {
        logic          s1_v;
        logic [TW-1:0] s1_ts;
        logic [DW-1:0] s1_err;
        logic [DW-1:0] s1_mag;
        logic          s1_ok;
        logic          out_v;
        logic [TW-1:0] out_ts;
        logic [FW-1:0] out_frac;
        logic          out_ok;
    } frac_st_t;

    frac_st_t          st_d, st_q;
    logic signed [DW:0] slope;
    logic              slope_ok;
    logic [DW-1:0]     slope_mag;
    logic [RW-1:0]     recip;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     scaled;
    logic [FW-1:0]     frac_sat;

    tis_recip_rom #(
        .DW (DW),
        .RW (RW)
    ) rom_i (
        .idx_i   (st_q.s1_mag),
        .recip_o (recip)
    );

    always_comb begin
        st_d = st_q;

        // stage 1: slope from the outer pair of the four-sample window
        slope     = $signed({1'b0, smp_i}) - $signed({1'b0, hit_early_i});
        slope_mag = slope[DW] ? DW'(-slope) : DW'(slope);
        if (hit_fall_i) begin
            slope_ok = slope[DW];
        end else begin
            slope_ok = !slope[DW] && (slope != '0);
        end
        st_d.s1_v = hit_i;
        if (hit_i) begin
            st_d.s1_ts  = hit_ts_i;
            st_d.s1_err = hit_err_i;
            st_d.s1_mag = slope_mag;
            st_d.s1_ok  = slope_ok;
        end

        // stage 2: lead = span * error / slope through the reciprocal table
        prod   = PW'(st_q.s1_err) * PW'(recip) * PW'(SLOPE_SPAN);
        scaled = prod >> SHIFT;
        if (scaled > PW'((1 << FW) - 1)) begin
            frac_sat = '1;
        end else begin
            frac_sat = FW'(scaled);
        end
        st_d.out_v = st_q.s1_v;
        if (st_q.s1_v) begin
            st_d.out_ts   = st_q.s1_ts;
            st_d.out_ok   = st_q.s1_ok;
            st_d.out_frac = st_q.s1_ok ? frac_sat : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o  = st_q.out_v;
    assign coarse_o = st_q.out_ts;
    assign frac_o   = st_q.out_frac;
    assign ok_o     = st_q.out_ok;

endmodule

// File: rtl/trig_interp_stamp.sv
module trig_interp_stamp #(
    parameter int unsigned DW   = 8,
    parameter int unsigned TW   = 32,
    parameter int unsigned FW   = 8,
    parameter int unsigned RW   = 16,
    parameter int unsigned HOLD = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] smp_i,
    input  logic [DW-1:0] level_i,
    input  logic          edge_fall_i,
    output logic          trig_valid_o,
    output logic [TW-1:0] trig_coarse_o,
    output logic [FW-1:0] trig_frac_o,
    output logic          trig_ok_o
);
    logic          hit;
    logic [TW-1:0] hit_ts;
    logic [DW-1:0] hit_err;
    logic [DW-1:0] hit_early;
    logic          hit_fall;

    tis_cross_detect #(
        .DW   (DW),
        .TW   (TW),
        .HOLD (HOLD)
    ) det_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .smp_i       (smp_i),
        .level_i     (level_i),
        .edge_fall_i (edge_fall_i),
        .hit_o       (hit),
        .hit_ts_o    (hit_ts),
        .hit_err_o   (hit_err),
        .hit_early_o (hit_early),
        .hit_fall_o  (hit_fall)
    );

    tis_frac_calc #(
        .DW (DW),
        .TW (TW),
        .FW (FW),
        .RW (RW)
    ) calc_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .smp_i       (smp_i),
        .hit_i       (hit),
        .hit_ts_i    (hit_ts),
        .hit_err_i   (hit_err),
        .hit_early_i (hit_early),
        .hit_fall_i  (hit_fall),
        .valid_o     (trig_valid_o),
        .coarse_o    (trig_coarse_o),
        .frac_o      (trig_frac_o),
        .ok_o        (trig_ok_o)
    );

endmodule

// File: rtl/tis_stamp_checker.sv
module tis_stamp_checker
    import tis_pkg::*;
#(
    parameter int unsigned TW   = 32,
    parameter int unsigned FW   = 8,
    parameter int unsigned HOLD = 5
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          trig_valid_o,
    input logic [TW-1:0] trig_coarse_o,
    input logic [FW-1:0] trig_frac_o,
    input logic          trig_ok_o
);
    localparam int unsigned HOLD_EFF = hold_floor(HOLD);

    logic [TW-1:0] edges_q;
    int unsigned   gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            edges_q <= '0;
            gap_q   <= HOLD_EFF;
        end else begin
            edges_q <= edges_q + 1'b1;
            if (trig_valid_o) begin
                gap_q <= 1;
            end else if (gap_q < HOLD_EFF) begin
                gap_q <= gap_q + 1;
            end
        end
    end

    assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_valid_o |=> !trig_valid_o);

    assert_coarse_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_valid_o |-> (trig_coarse_o == edges_q - TW'(3)));

    assert_bad_slope_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_valid_o && !trig_ok_o) |-> (trig_frac_o == '0));

    assert_holdoff_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_valid_o |-> (gap_q >= HOLD_EFF));

    assert_outputs_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trig_valid_o |-> ($stable(trig_coarse_o) && $stable(trig_frac_o) && $stable(trig_ok_o)));

endmodule

bind trig_interp_stamp tis_stamp_checker #(
    .TW   (TW),
    .FW   (FW),
    .HOLD (HOLD)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trig_valid_o  (trig_valid_o),
    .trig_coarse_o (trig_coarse_o),
    .trig_frac_o   (trig_frac_o),
    .trig_ok_o     (trig_ok_o)
);

// File: tb/trig_interp_stamp_tb_top.sv
`timescale 1ns/1ps
module trig_interp_stamp_tb_top;
    localparam int H = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  smp = '0;
    logic [7:0]  lvl = '0;
    logic        fall = 1'b0;
    logic        vld;
    logic [31:0] coarse;
    logic [7:0]  frac;
    logic        ok;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    trig_interp_stamp dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .smp_i         (smp),
        .level_i       (lvl),
        .edge_fall_i   (fall),
        .trig_valid_o  (vld),
        .trig_coarse_o (coarse),
        .trig_frac_o   (frac),
        .trig_ok_o     (ok)
    );

    // reference model state
    int  hist [int];
    int  k = 0;
    int  last_fire = -100;
    bit  pend = 0;
    int  pn, pe, pearly;
    bit  pfall;
    bit  ev [int];
    int  e_coarse [int];
    int  e_frac [int];
    bit  e_ok [int];
    bit  e_fall [int];
    bit  blocked [int];
    int  lc = 0, lf = 0;
    bit  lo = 0;

    task automatic chk(input bit good, input string tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (slot %0d)", tag, what, act, exp, k);
        end
    endtask

    task automatic check_slot();
        if (ev.exists(k)) begin
            chk(vld == 1'b1, e_fall[k] ? "R3" : "R2", "strobe", vld, 1);
            chk(coarse == 32'(e_coarse[k]), "R4", "coarse", coarse, e_coarse[k]);
            chk(ok == e_ok[k], "R6", "ok flag", ok, e_ok[k]);
            chk(frac == 8'(e_frac[k]), e_ok[k] ? "R5" : "R6", "fraction", frac, e_frac[k]);
            lc = e_coarse[k]; lf = e_frac[k]; lo = e_ok[k];
        end else begin
            chk(vld == 1'b0, blocked.exists(k) ? "R7" : "R2", "no strobe", vld, 0);
            chk(coarse == 32'(lc) && frac == 8'(lf) && ok == lo, "R8", "held result",
                {coarse, frac, 7'b0, ok}, {32'(lc), 8'(lf), 7'b0, lo});
        end
    endtask

    task automatic model(input int s);
        hist[k] = s;
        if (pend && k == pn + 1) begin
            int d, mag, r, f;
            bit good;
            d    = s - pearly;
            good = pfall ? (d < 0) : (d > 0);
            mag  = (d < 0) ? -d : d;
            r    = (mag == 0) ? 0 : 65535 / mag;
            f    = (3 * pe * r) >>> 8;
            if (f > 255) f = 255;
            if (!good) f = 0;
            ev[pn+3] = 1; e_coarse[pn+3] = pn; e_frac[pn+3] = f;
            e_ok[pn+3] = good; e_fall[pn+3] = pfall;
            pend = 0;
        end
        if (k >= 2) begin
            int p;
            bit cr;
            p  = hist[k-1];
            cr = fall ? (p > int'(lvl) && s <= int'(lvl)) : (p < int'(lvl) && s >= int'(lvl));
            if (cr) begin
                if (k - last_fire >= H) begin
                    pend = 1; pn = k; pfall = fall; pearly = hist[k-2];
                    pe = fall ? int'(lvl) - s : s - int'(lvl);
                    last_fire = k;
                end else begin
                    blocked[k+3] = 1;
                end
            end
        end
    endtask

    // entered at a falling edge; leaves at the next falling edge
    task automatic run(input int s);
        check_slot();
        smp = 8'(s);
        model(s);
        k++;
        @(negedge clk);
    endtask

    task automatic play(input int vals[$]);
        foreach (vals[i]) run(vals[i]);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(vld == 0, "R1", "reset strobe", vld, 0);
        chk(coarse == 0, "R1", "reset coarse", coarse, 0);
        chk(frac == 0 && ok == 0, "R1", "reset frac/ok", {frac, ok}, 0);
        lvl = 8'd100; fall = 0;
        rst_n = 1'b1;
        // R2: flat below level, then a ramp hitting the level exactly (e = 0)
        play('{10, 10, 10, 10, 10, 10, 40, 70, 100, 130, 160, 190, 200, 200, 200});
        // R3 direction not selected: a falling pass gives nothing
        play('{50, 50, 50, 50, 50});
        // R5: ordinary interpolation
        play('{60, 90, 112, 125, 140, 140, 140, 140, 140, 140});
        // R5: one-step jump with unit slope saturates at 255
        play('{10, 10, 10, 10, 10, 99, 99, 250, 100, 10, 10, 10, 10, 10, 10});
        // R6: reversed slope after a valid rising trigger on 150
        play('{150, 150, 150, 150, 150, 150, 150, 90, 120, 60, 40, 40, 40, 40, 40, 40});
        // R6: flat slope (x[n+1] == x[n-2])
        play('{130, 130, 130, 130, 130, 130, 90, 120, 130, 130, 130, 130, 130, 130});
        // R3: falling trigger
        lvl = 8'd128; fall = 1;
        play('{200, 200, 200, 200, 200, 180, 150, 120, 90, 60, 60, 60, 60, 60, 60});
        // R7: fast toggling inside the holdoff
        lvl = 8'd100; fall = 0;
        for (int i = 0; i < 8; i++) play('{50, 150});
        play('{150, 150, 150, 150, 150, 150});
        // random data with polarity and level changes
        for (int seg = 0; seg < 12; seg++) begin
            fall = seg[0];
            lvl  = 8'($urandom_range(40, 215));
            for (int i = 0; i < 60; i++) run(int'($urandom_range(0, 255)));
        end
        for (int i = 0; i < 10; i++) run(0);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule